// File: doc/BRIEF.md
# Circuit-Switched Channel Setup Controller

This block is the setup controller for one incoming lane of a switch in a two-dimensional mesh that uses circuit switching. The upstream side raises a level request that carries a signed (dx, dy) offset to the destination, plus a select bit that picks one of the two local module ports when the offset is zero. The controller finds the shortest-path output directions, of which there are at most two. On each candidate port it reserves the lowest free lane and raises the downstream request on that lane. It then collects a grant or a deny from every forwarded lane.

When all replies are in, the controller keeps one path and answers upstream. If both directions grant, it keeps the path whose port has fewer engaged lanes, and on a tie the path with the lower port number. It drops the request on the other path, and that drop is the release signal to the next switch. If every forwarded request is denied, or if no candidate port has a free lane, it answers deny and keeps no lane.

The kept lane is reported as a port/lane select for the crossbar, and it stays held while the upstream request stays high. When the upstream request falls, the data phase is over and the controller frees everything. Lane occupancy by other channels in the same switch arrives as a bit vector.

Top module: `cs_chan_setup`

## Requirements
- R1: After reset all outputs are low: up_gnt, up_dny, dn_req, sel_valid, sel_port and sel_lane.
- R2: Lane vectors are indexed port*LANES+lane. The port numbers are left=0, right=1, up=2, down=3, first local=4 and second local=5. The first candidate is right when dx>0 and left when dx<0. When dx=0 it is up when dy>0 and down when dy<0. The second candidate exists only when both dx and dy are non-zero; it is up or down by the sign of dy. A zero offset selects local port 4 when up_loc_sel=0 and port 5 when up_loc_sel=1.
- R3: One cycle after an accepted request, dn_req is high on the lowest-numbered lane that lane_busy does not mark on each candidate port that has a free lane. No other dn_req bit is high.
- R4: If no candidate port has a free lane, up_dny rises one cycle after the request and no dn_req bit rises. up_dny stays high until up_req falls, and the controller is idle in the cycle after that.
- R5: While any forwarded lane still lacks a reply, up_gnt and up_dny stay low and both reservations stay in place.
- R6: If every forwarded lane is denied, then in the cycle after the last reply all dn_req bits are low and up_dny is high.
- R7: If both forwarded lanes grant, the kept lane is on the port with fewer engaged lanes. A port's engaged lanes are those marked busy plus the one this channel holds there. On equal counts the lower port number wins. The other lane's dn_req falls in the same cycle that up_gnt rises.
- R8: If one forwarded lane grants and the other denies, the granting lane is kept and the denied lane's dn_req falls when up_gnt rises.
- R9: While up_gnt is high, sel_valid is high and sel_port/sel_lane name the single lane whose dn_req is high.
- R10: When up_req falls while up_gnt is high, in the next cycle dn_req is all low, up_gnt and sel_valid are low, and a new request can be accepted.
- R11: up_gnt and up_dny are never high together, and at most two dn_req bits are high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream channel request, held as a level for the whole channel life |
| up_dx | input | CW | Signed horizontal offset to destination |
| up_dy | input | CW | Signed vertical offset to destination |
| up_loc_sel | input | 1 | Local port choice for a zero offset (0 = port 4, 1 = port 5) |
| up_gnt | output | 1 | Grant to requester, held through the data phase |
| up_dny | output | 1 | Deny to requester, held until the request falls |
| lane_busy | input | 6*LANES | Lanes engaged by other channels in this switch |
| dn_req | output | 6*LANES | Downstream request per output lane; falling edge releases the lane |
| dn_gnt | input | 6*LANES | Downstream grant per output lane |
| dn_dny | input | 6*LANES | Downstream deny per output lane |
| sel_valid | output | 1 | Crossbar select is valid |
| sel_port | output | 3 | Output port of the kept lane |
| sel_lane | output | LW | Lane index of the kept lane |

## Verification
The assertions assume a well-behaved environment. Other channels never mark a lane busy while this controller holds it. The requester keeps up_req high until it gets a grant or a deny. Each downstream neighbour raises at most one of grant or deny on a lane, and only while that lane is requested. The bench follows these rules. It sets lane_busy at the same moment it raises the request and holds it fixed for the whole transaction. It drives replies only on lanes whose dn_req it expects to be high. It clears all replies in the same step that it drops the upstream request.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int NPORT = 6;
  localparam int PW    = 3;

  typedef enum logic [PW-1:0] {
    P_LEFT  = 3'd0,
    P_RIGHT = 3'd1,
    P_UP    = 3'd2,
    P_DOWN  = 3'd3,
    P_LLOC  = 3'd4,
    P_RLOC  = 3'd5
  } port_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_XFER = 2'd2,
    S_DENY = 2'd3
  } state_e;
endpackage

// File: rtl/cs_route_calc.sv
module cs_route_calc
  import cs_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic signed [CW-1:0] dx,
  input  logic signed [CW-1:0] dy,
  input  logic                 loc_sel,
  output port_e                c0_port,
  output port_e                c1_port,
  output logic                 c1_use
);
  always_comb begin
    c0_port = P_LLOC;
    c1_port = P_UP;
    c1_use  = 1'b0;
    if (dx != '0) begin
      c0_port = (dx < 0) ? P_LEFT : P_RIGHT;
      c1_use  = (dy != '0);
      c1_port = (dy < 0) ? P_DOWN : P_UP;
    end else if (dy != '0) begin
      c0_port = (dy < 0) ? P_DOWN : P_UP;
    end else begin
      c0_port = loc_sel ? P_RLOC : P_LLOC;
    end
  end
endmodule

// File: rtl/cs_port_status.sv
module cs_port_status #(
  parameter int LANES = 3,
  parameter int LW    = 2,
  parameter int CNTW  = 2
) (
  input  logic [LANES-1:0] busy,
  output logic             free,
  output logic [LW-1:0]    idx,
  output logic [CNTW-1:0]  cnt
);
  always_comb begin
    free = 1'b0;
    idx  = '0;
    cnt  = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (!busy[l]) begin
        free = 1'b1;
        idx  = LW'(l);
      end
    end
    for (int l = 0; l < LANES; l++) begin
      cnt = cnt + CNTW'(busy[l]);
    end
  end
endmodule

// File: rtl/cs_path_pick.sv
module cs_path_pick
  import cs_pkg::*;
#(
  parameter int CNTW = 2
) (
  input  logic            g0,
  input  logic            g1,
  input  port_e           p0,
  input  port_e           p1,
  input  logic [CNTW-1:0] n0,
  input  logic [CNTW-1:0] n1,
  output logic            take1
);
  logic second_cheaper;
  always_comb begin
    second_cheaper = (n1 < n0) || ((n1 == n0) && (p1 < p0));
    take1 = g1 && (!g0 || second_cheaper);
  end
endmodule

// File: rtl/cs_chan_setup.sv
module cs_chan_setup
  import cs_pkg::*;
#(
  parameter int LANES = 3,
  parameter int CW    = 4,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   up_req,
  input  logic signed [CW-1:0]   up_dx,
  input  logic signed [CW-1:0]   up_dy,
  input  logic                   up_loc_sel,
  output logic                   up_gnt,
  output logic                   up_dny,
  input  logic [NPORT*LANES-1:0] lane_busy,
  output logic [NPORT*LANES-1:0] dn_req,
  input  logic [NPORT*LANES-1:0] dn_gnt,
  input  logic [NPORT*LANES-1:0] dn_dny,
  output logic                   sel_valid,
  output logic [PW-1:0]          sel_port,
  output logic [LW-1:0]          sel_lane
);
  localparam int NL   = NPORT * LANES;
  localparam int CNTW = $clog2(LANES + 1);
  localparam int BW   = (NL > 1) ? $clog2(NL) : 1;

  state_e        st;
  logic [NL-1:0] rsv_q;
  port_e         s0_port, s1_port;
  logic [LW-1:0] s0_lane, s1_lane;
  logic          s0_ok, s1_ok;
  logic          g0_q, d0_q, g1_q, d1_q;

  // per-port lane status
  logic [NL-1:0]   occ;
  logic [NPORT-1:0] pfree;
  logic [LW-1:0]   pidx [NPORT];
  logic [CNTW-1:0] pcnt [NPORT];

  assign occ = lane_busy | rsv_q;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      cs_port_status #(.LANES(LANES), .LW(LW), .CNTW(CNTW)) u_stat (
        .busy (occ[p*LANES +: LANES]),
        .free (pfree[p]),
        .idx  (pidx[p]),
        .cnt  (pcnt[p])
      );
    end
  endgenerate

  // candidate directions
  port_e c0_port, c1_port;
  logic  c1_use, c0_ok, c1_ok;

  cs_route_calc #(.CW(CW)) u_route (
    .dx      (up_dx),
    .dy      (up_dy),
    .loc_sel (up_loc_sel),
    .c0_port (c0_port),
    .c1_port (c1_port),
    .c1_use  (c1_use)
  );

  assign c0_ok = pfree[c0_port];
  assign c1_ok = c1_use && pfree[c1_port];

  function automatic logic [NL-1:0] lane_bit(input port_e p, input logic [LW-1:0] l);
    return NL'(1) << (int'(p) * LANES + int'(l));
  endfunction

  // reply collection
  logic [BW-1:0] b0, b1;
  logic          g0_any, d0_any, g1_any, d1_any, all_rep, take1;

  always_comb begin
    b0      = BW'(int'(s0_port) * LANES + int'(s0_lane));
    b1      = BW'(int'(s1_port) * LANES + int'(s1_lane));
    g0_any  = s0_ok && (g0_q || dn_gnt[b0]);
    d0_any  = s0_ok && (d0_q || dn_dny[b0]);
    g1_any  = s1_ok && (g1_q || dn_gnt[b1]);
    d1_any  = s1_ok && (d1_q || dn_dny[b1]);
    all_rep = (!s0_ok || g0_any || d0_any) && (!s1_ok || g1_any || d1_any);
  end

  cs_path_pick #(.CNTW(CNTW)) u_pick (
    .g0    (g0_any),
    .g1    (g1_any),
    .p0    (s0_port),
    .p1    (s1_port),
    .n0    (pcnt[s0_port]),
    .n1    (pcnt[s1_port]),
    .take1 (take1)
  );

  // channel state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      rsv_q     <= '0;
      up_gnt    <= 1'b0;
      up_dny    <= 1'b0;
      sel_valid <= 1'b0;
      sel_port  <= '0;
      sel_lane  <= '0;
      s0_port   <= P_LEFT;
      s1_port   <= P_LEFT;
      s0_lane   <= '0;
      s1_lane   <= '0;
      s0_ok     <= 1'b0;
      s1_ok     <= 1'b0;
      g0_q      <= 1'b0;
      d0_q      <= 1'b0;
      g1_q      <= 1'b0;
      d1_q      <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (up_req) begin
            g0_q    <= 1'b0;
            d0_q    <= 1'b0;
            g1_q    <= 1'b0;
            d1_q    <= 1'b0;
            s0_port <= c0_port;
            s1_port <= c1_port;
            s0_lane <= pidx[c0_port];
            s1_lane <= pidx[c1_port];
            s0_ok   <= c0_ok;
            s1_ok   <= c1_ok;
            if (c0_ok || c1_ok) begin
              rsv_q <= (c0_ok ? lane_bit(c0_port, pidx[c0_port]) : '0)
                     | (c1_ok ? lane_bit(c1_port, pidx[c1_port]) : '0);
              st    <= S_WAIT;
            end else begin
              up_dny <= 1'b1;
              st     <= S_DENY;
            end
          end
        end
        S_WAIT: begin
          g0_q <= g0_any;
          d0_q <= d0_any;
          g1_q <= g1_any;
          d1_q <= d1_any;
          if (all_rep) begin
            if (g0_any || g1_any) begin
              up_gnt    <= 1'b1;
              sel_valid <= 1'b1;
              if (take1) begin
                rsv_q    <= lane_bit(s1_port, s1_lane);
                sel_port <= s1_port;
                sel_lane <= s1_lane;
              end else begin
                rsv_q    <= lane_bit(s0_port, s0_lane);
                sel_port <= s0_port;
                sel_lane <= s0_lane;
              end
              st <= S_XFER;
            end else begin
              rsv_q  <= '0;
              up_dny <= 1'b1;
              st     <= S_DENY;
            end
          end
        end
        S_XFER: begin
          if (!up_req) begin
            rsv_q     <= '0;
            up_gnt    <= 1'b0;
            sel_valid <= 1'b0;
            st        <= S_IDLE;
          end
        end
        S_DENY: begin
          if (!up_req) begin
            up_dny <= 1'b0;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dn_req = rsv_q;
endmodule

// File: rtl/cs_chan_setup_chk.sv
module cs_chan_setup_chk
  import cs_pkg::*;
#(
  parameter int LANES = 3,
  parameter int LW    = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   up_req,
  input logic                   up_gnt,
  input logic                   up_dny,
  input logic [NPORT*LANES-1:0] lane_busy,
  input logic [NPORT*LANES-1:0] dn_req,
  input logic                   sel_valid,
  input logic [PW-1:0]          sel_port,
  input logic [LW-1:0]          sel_lane
);
  AST_GNT_DNY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(up_gnt && up_dny)); // R11

  AST_MAX_TWO_LANES: assert property (@(posedge clk) disable iff (rst)
    $countones(dn_req) <= 2); // R11

  AST_XFER_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    up_gnt |-> ($countones(dn_req) == 1)); // R7

  AST_RSV_FREE: assert property (@(posedge clk) disable iff (rst)
    (dn_req & lane_busy) == '0); // R3

  AST_DENY_CLEAN: assert property (@(posedge clk) disable iff (rst)
    up_dny |-> (dn_req == '0)); // R6

  AST_DENY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up_dny && up_req) |=> up_dny); // R4

  AST_END_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (up_gnt && !up_req) |=> ((dn_req == '0) && !up_gnt)); // R10

  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> dn_req[int'(sel_port) * LANES + int'(sel_lane)]); // R9
endmodule

bind cs_chan_setup cs_chan_setup_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .up_req    (up_req),
  .up_gnt    (up_gnt),
  .up_dny    (up_dny),
  .lane_busy (lane_busy),
  .dn_req    (dn_req),
  .sel_valid (sel_valid),
  .sel_port  (sel_port),
  .sel_lane  (sel_lane)
);

// File: tb/cs_chan_setup_test.sv
module cs_chan_setup_test;
  localparam int LANES = 3;
  localparam int CW    = 4;
  localparam int NL    = 18;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 up_req = 1'b0;
  logic signed [CW-1:0] up_dx = '0;
  logic signed [CW-1:0] up_dy = '0;
  logic                 up_loc_sel = 1'b0;
  logic                 up_gnt, up_dny;
  logic [NL-1:0]        lane_busy = '0;
  logic [NL-1:0]        dn_req;
  logic [NL-1:0]        dn_gnt = '0;
  logic [NL-1:0]        dn_dny = '0;
  logic                 sel_valid;
  logic [2:0]           sel_port;
  logic [1:0]           sel_lane;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cs_chan_setup #(.LANES(LANES), .CW(CW)) uut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_dx(up_dx), .up_dy(up_dy),
    .up_loc_sel(up_loc_sel), .up_gnt(up_gnt), .up_dny(up_dny),
    .lane_busy(lane_busy), .dn_req(dn_req), .dn_gnt(dn_gnt), .dn_dny(dn_dny),
    .sel_valid(sel_valid), .sel_port(sel_port), .sel_lane(sel_lane)
  );

  typedef struct packed {
    logic signed [3:0] dx;
    logic signed [3:0] dy;
    logic              loc;
    logic [17:0]       busy;
    logic [17:0]       req;
    logic [17:0]       g;
    logic [17:0]       d;
    logic [17:0]       fin;
    logic              gnt;
    logic              dny;
    logic [2:0]        sp;
    logic [1:0]        sl;
  } vec_t;

  // bit index = port*3 + lane; ports L=0 R=1 U=2 D=3 loc4 loc5
  localparam vec_t TBL [10] = '{
    '{ 4'sd2,  4'sd0, 1'b0, 18'h0,    18'h8,    18'h8,    18'h0,  18'h8,    1'b1, 1'b0, 3'd1, 2'd0},
    '{-4'sd1,  4'sd3, 1'b0, 18'h0C1,  18'h102,  18'h102,  18'h0,  18'h2,    1'b1, 1'b0, 3'd0, 2'd1},
    '{ 4'sd1, -4'sd1, 1'b0, 18'h0,    18'h208,  18'h208,  18'h0,  18'h8,    1'b1, 1'b0, 3'd1, 2'd0},
    '{ 4'sd1,  4'sd1, 1'b0, 18'h38,   18'h40,   18'h0,    18'h40, 18'h0,    1'b0, 1'b1, 3'd0, 2'd0},
    '{-4'sd2, -4'sd2, 1'b0, 18'h0,    18'h201,  18'h200,  18'h1,  18'h200,  1'b1, 1'b0, 3'd3, 2'd0},
    '{ 4'sd0,  4'sd0, 1'b1, 18'h0,    18'h8000, 18'h8000, 18'h0,  18'h8000, 1'b1, 1'b0, 3'd5, 2'd0},
    '{ 4'sd0,  4'sd0, 1'b0, 18'h1000, 18'h2000, 18'h2000, 18'h0,  18'h2000, 1'b1, 1'b0, 3'd4, 2'd1},
    '{ 4'sd3,  4'sd2, 1'b0, 18'h1F8,  18'h0,    18'h0,    18'h0,  18'h0,    1'b0, 1'b1, 3'd0, 2'd0},
    '{ 4'sd1,  4'sd1, 1'b0, 18'h8,    18'h50,   18'h50,   18'h0,  18'h40,   1'b1, 1'b0, 3'd2, 2'd0},
    '{-4'sd1,  4'sd1, 1'b0, 18'h0,    18'h41,   18'h0,    18'h41, 18'h0,    1'b0, 1'b1, 3'd0, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic release_chan();
    @(negedge clk);
    up_req = 1'b0; dn_gnt = '0; dn_dny = '0;
    @(negedge clk);
    chk("R10 dn_req", 32'(dn_req), 32'h0);
    chk("R10 up_gnt", 32'(up_gnt), 32'h0);
    chk("R10 up_dny", 32'(up_dny), 32'h0);
    chk("R10 sel_valid", 32'(sel_valid), 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 up_gnt", 32'(up_gnt), 0);
    chk("R1 up_dny", 32'(up_dny), 0);
    chk("R1 dn_req", 32'(dn_req), 0);
    chk("R1 sel", {sel_valid, sel_port, sel_lane}, 0);

    // table walk: R2 R3 R4 R6 R7 R8 R9 R10
    for (int i = 0; i < 10; i++) begin
      v = TBL[i];
      @(negedge clk);
      lane_busy = v.busy; up_dx = v.dx; up_dy = v.dy; up_loc_sel = v.loc; up_req = 1'b1;
      @(negedge clk);
      chk($sformatf("R2/R3 vec%0d dn_req", i), 32'(dn_req), 32'(v.req));
      if (v.req == '0) begin
        chk($sformatf("R4 vec%0d up_dny", i), 32'(up_dny), 1);
      end else begin
        dn_gnt = v.g; dn_dny = v.d;
        @(negedge clk);
        chk($sformatf("R6/R7/R8 vec%0d kept", i), 32'(dn_req), 32'(v.fin));
        chk($sformatf("R7/R8 vec%0d up_gnt", i), 32'(up_gnt), 32'(v.gnt));
        chk($sformatf("R6 vec%0d up_dny", i), 32'(up_dny), 32'(v.dny));
        if (v.gnt)
          chk($sformatf("R9 vec%0d sel", i), {sel_valid, sel_port, sel_lane}, {1'b1, v.sp, v.sl});
        dn_gnt = v.g & v.fin; dn_dny = '0;
      end
      release_chan();
    end

    // R5: one grant arrives, the other reply is late
    @(negedge clk);
    lane_busy = '0; up_dx = 4'sd1; up_dy = 4'sd1; up_req = 1'b1;
    @(negedge clk);
    chk("R3 two lanes", 32'(dn_req), 32'h48);
    dn_gnt = 18'h8;
    @(negedge clk);
    chk("R5 no gnt yet", 32'(up_gnt), 0);
    chk("R5 both held", 32'(dn_req), 32'h48);
    @(negedge clk);
    chk("R5 still waiting", {up_gnt, up_dny}, 0);
    dn_dny = 18'h40;
    @(negedge clk);
    chk("R8 grant kept", 32'(dn_req), 32'h8);
    chk("R8 up_gnt", 32'(up_gnt), 1);
    chk("R11 excl", 32'(up_gnt & up_dny), 0);
    dn_dny = '0;
    release_chan();

    // R4: deny held while request stays up
    @(negedge clk);
    lane_busy = 18'h38; up_dx = 4'sd2; up_dy = 4'sd0; up_req = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 deny held", 32'(up_dny), 1);
    chk("R4 no lanes", 32'(dn_req), 0);
    release_chan();

    // R1: reset in data phase clears everything
    @(negedge clk);
    lane_busy = '0; up_dx = 4'sd0; up_dy = -4'sd3; up_req = 1'b1;
    @(negedge clk);
    chk("R2 down lane", 32'(dn_req), 32'h200);
    dn_gnt = 18'h200;
    @(negedge clk);
    chk("R9 down sel", {sel_valid, sel_port, sel_lane}, {1'b1, 3'd3, 2'd0});
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset", {up_gnt, up_dny, sel_valid}, 0);
    chk("R1 mid reset dn_req", 32'(dn_req), 0);
    rst = 1'b0; up_req = 1'b0; dn_gnt = '0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule